// File: doc/BRIEF.md
# Speculative Load Alias Table

This block tracks loads that a compiler has moved above earlier stores that might write the same bytes. When such an early load executes, it records its destination register, its address and its access size in a small fully associative table. Every store that follows is compared against all recorded entries at once. Any entry whose byte range overlaps the store's byte range is silently invalidated.

When the program reaches the point where the load originally sat, a check operation names the destination register. The table answers in the same cycle. A pass means the early value is still good. A fail means the recovery code must run, either because a store overlapped the load or because the entry is no longer present. An entry can be missing because it was never recorded, because it was evicted, because it was flushed, or because an earlier check cleared it.

Each register has at most one entry. When all slots are in use, a new register takes a slot in round-robin order. A flush input empties the whole table.

Top module: `spec_load_table`

## Requirements
- R1: After an insert of register r in cycle n, a check of r in cycle n+1 or later asserts `chk_pass_o` in the same cycle as `chk_valid_i`, as long as no invalidation has happened in between. A check sees the table state as of the last clock edge.
- R2: A check of a register that has no valid entry asserts `chk_fail_o` and not `chk_pass_o`. Out of reset no register has a valid entry.
- R3: A store invalidates every entry whose byte range overlaps the store's byte range. Size code s (0 to 3) covers 2^s bytes starting at the given address, so codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R4: A store whose byte range does not overlap an entry leaves that entry valid. This includes a store that ends exactly where the entry begins, and one that begins right after the entry ends.
- R5: An insert for a register that already has a valid entry replaces that entry's address and size. After that, only the new range is tracked for that register, and there is never more than one valid entry per register.
- R6: When a store and an insert arrive in the same cycle, the insert takes effect after the store. The new entry is valid even if its range overlaps the store.
- R7: A new register takes the lowest-numbered free slot. When no slot is free, it replaces slots in round-robin order: the first such replacement after reset uses slot 0, and each later one uses the next slot. A check of the evicted register then fails.
- R8: A check that passes with `chk_clear_i` high invalidates the entry, so a later check of that register fails. A check with `chk_clear_i` low leaves the entry valid.
- R9: `flush_i` invalidates every entry at the next edge. It takes precedence over an insert in the same cycle, so that insert is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| ins_valid_i | input | 1 | Record an early load |
| ins_reg_i | input | REG_W | Destination register of the early load |
| ins_addr_i | input | ADDR_W | Byte address of the early load |
| ins_size_i | input | 2 | Size code of the early load (2^code bytes) |
| st_valid_i | input | 1 | A store is snooped this cycle |
| st_addr_i | input | ADDR_W | Byte address of the store |
| st_size_i | input | 2 | Size code of the store (2^code bytes) |
| chk_valid_i | input | 1 | Check request |
| chk_reg_i | input | REG_W | Register being checked |
| chk_clear_i | input | 1 | Invalidate the entry if the check passes |
| chk_pass_o | output | 1 | Check passed; the early value may be used |
| chk_fail_o | output | 1 | Check failed; recovery code is needed |

## Verification
Some properties are checked on every cycle:
- a check hit never matches more than one slot;
- a check right after an insert passes, even when a store arrived in the same cycle as the insert;
- a matching store empties the slot it hits, unless that slot is being rewritten;
- a flush leaves no valid slot;
- a clearing check makes the next check of the same register fail.

Some behaviour only the directed scenarios can show: the byte-overlap boundaries for adjacent ranges and for ranges of different sizes, the order in which slots are chosen when the table is full, and the fact that a rewrite stops tracking the register's old address.

// File: rtl/slt_pkg.sv
package slt_pkg;
   typedef enum logic [1:0] {
      SZ_1B = 2'd0,
      SZ_2B = 2'd1,
      SZ_4B = 2'd2,
      SZ_8B = 2'd3
   } acc_size_e;

   localparam int unsigned SIZE_W = 2;
endpackage

// File: rtl/slt_overlap.sv
module slt_overlap #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [1:0]        a_size,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [1:0]        b_size,
   output logic              hit
);
   localparam int unsigned XW = ADDR_W + 1;

   logic [XW-1:0] a_lo, a_end, b_lo, b_end;

   always_comb begin
      a_lo  = {1'b0, a_addr};
      b_lo  = {1'b0, b_addr};
      a_end = a_lo + (XW'(1) << a_size);
      b_end = b_lo + (XW'(1) << b_size);
      hit   = (a_lo < b_end) && (b_lo < a_end);
   end
endmodule

// File: rtl/slt_entry.sv
module slt_entry #(
   parameter int unsigned REG_W  = 7,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr,
   input  logic [REG_W-1:0]  wr_reg,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_size,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [1:0]        st_size,
   input  logic              clr,
   output logic              valid,
   output logic [REG_W-1:0]  tag
);
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        size_q;
   logic              ovl;
   logic              snoop_kill;

   slt_overlap #(.ADDR_W(ADDR_W)) u_ovl (
      .a_addr (addr_q),
      .a_size (size_q),
      .b_addr (st_addr),
      .b_size (st_size),
      .hit    (ovl)
   );

   assign snoop_kill = st_valid && ovl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         tag    <= '0;
         addr_q <= '0;
         size_q <= '0;
      end else if (flush) begin
         valid  <= 1'b0;
      end else if (wr) begin
         valid  <= 1'b1;
         tag    <= wr_reg;
         addr_q <= wr_addr;
         size_q <= wr_size;
      end else if (snoop_kill || clr) begin
         valid  <= 1'b0;
      end
   end

   AST_STORE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && snoop_kill && !wr) |=> !valid); // R3
endmodule

// File: rtl/slt_slot_pick.sv
module slt_slot_pick #(
   parameter int unsigned ENTRIES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               ins_valid,
   input  logic [ENTRIES-1:0] valid,
   input  logic [ENTRIES-1:0] reg_hit,
   output logic [ENTRIES-1:0] sel
);
   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] hit_idx, free_idx, pick;
   logic             any_hit, any_free, evict;

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (reg_hit[i]) hit_idx  = IDX_W'(i);
         if (!valid[i])  free_idx = IDX_W'(i);
      end
      any_hit  = |reg_hit;
      any_free = ~&valid;
      evict    = !any_hit && !any_free;
      if (any_hit)       pick = hit_idx;
      else if (any_free) pick = free_idx;
      else               pick = rr_q;
      sel = '0;
      sel[pick] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_q <= '0;
      else if (ins_valid && !flush && evict)
         rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
   end

   AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !flush && &valid && reg_hit == '0) |=> (rr_q != $past(rr_q))); // R7
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned REG_W   = 7,
   parameter int unsigned ADDR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              ins_valid_i,
   input  logic [REG_W-1:0]  ins_reg_i,
   input  logic [ADDR_W-1:0] ins_addr_i,
   input  logic [1:0]        ins_size_i,
   input  logic              st_valid_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic [1:0]        st_size_i,
   input  logic              chk_valid_i,
   input  logic [REG_W-1:0]  chk_reg_i,
   input  logic              chk_clear_i,
   output logic              chk_pass_o,
   output logic              chk_fail_o
);
   import slt_pkg::*;

   generate
      if (ENTRIES < 2)       begin : g_bad_depth $error("ENTRIES must be at least 2"); end
      if (REG_W < 1)         begin : g_bad_reg   $error("REG_W must be positive"); end
      if (ADDR_W < 4)        begin : g_bad_addr  $error("ADDR_W must be at least 4"); end
      if (SIZE_W != 2)       begin : g_bad_size  $error("size code must be 2 bits"); end
   endgenerate

   logic [ENTRIES-1:0] vld, ins_hit, chk_hit, wr_sel, clr;
   logic [REG_W-1:0]   tag [ENTRIES];

   slt_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_i),
      .ins_valid (ins_valid_i),
      .valid     (vld),
      .reg_hit   (ins_hit),
      .sel       (wr_sel)
   );

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         assign ins_hit[e] = vld[e] && (tag[e] == ins_reg_i);
         assign chk_hit[e] = vld[e] && (tag[e] == chk_reg_i);
         assign clr[e]     = chk_valid_i && chk_clear_i && chk_hit[e];

         slt_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush_i),
            .wr       (ins_valid_i && wr_sel[e]),
            .wr_reg   (ins_reg_i),
            .wr_addr  (ins_addr_i),
            .wr_size  (ins_size_i),
            .st_valid (st_valid_i),
            .st_addr  (st_addr_i),
            .st_size  (st_size_i),
            .clr      (clr[e]),
            .valid    (vld[e]),
            .tag      (tag[e])
         );
      end
   endgenerate

   assign chk_pass_o = chk_valid_i && (|chk_hit);
   assign chk_fail_o = chk_valid_i && !(|chk_hit);

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (vld == '0)); // R9

   AST_ONE_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid_i |-> $onehot0(chk_hit)); // R5

   AST_INSERT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ins_valid_i && !flush_i) && chk_valid_i && chk_reg_i == $past(ins_reg_i))
      |-> chk_pass_o); // R6

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(chk_pass_o && chk_clear_i && !(ins_valid_i && ins_reg_i == chk_reg_i))
       && chk_valid_i && chk_reg_i == $past(chk_reg_i)) |-> !chk_pass_o); // R8
endmodule

// File: tb/tb_spec_load_table.sv
module tb_spec_load_table;
   localparam int unsigned REG_W  = 7;
   localparam int unsigned ADDR_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush_i = 1'b0;
   logic              ins_valid_i = 1'b0;
   logic [REG_W-1:0]  ins_reg_i = '0;
   logic [ADDR_W-1:0] ins_addr_i = '0;
   logic [1:0]        ins_size_i = '0;
   logic              st_valid_i = 1'b0;
   logic [ADDR_W-1:0] st_addr_i = '0;
   logic [1:0]        st_size_i = '0;
   logic              chk_valid_i = 1'b0;
   logic [REG_W-1:0]  chk_reg_i = '0;
   logic              chk_clear_i = 1'b0;
   logic              chk_pass_o, chk_fail_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spec_load_table #(.ENTRIES(16), .REG_W(REG_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .ins_valid_i(ins_valid_i), .ins_reg_i(ins_reg_i),
      .ins_addr_i(ins_addr_i), .ins_size_i(ins_size_i),
      .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
      .chk_valid_i(chk_valid_i), .chk_reg_i(chk_reg_i), .chk_clear_i(chk_clear_i),
      .chk_pass_o(chk_pass_o), .chk_fail_o(chk_fail_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
      ins_valid_i = 1'b0;
      st_valid_i  = 1'b0;
      flush_i     = 1'b0;
      chk_valid_i = 1'b0;
      chk_clear_i = 1'b0;
   endtask

   task automatic ins(input int r, input int a, input int sz);
      ins_valid_i = 1'b1;
      ins_reg_i   = REG_W'(r);
      ins_addr_i  = ADDR_W'(a);
      ins_size_i  = 2'(sz);
      tick();
   endtask

   task automatic st(input int a, input int sz);
      st_valid_i = 1'b1;
      st_addr_i  = ADDR_W'(a);
      st_size_i  = 2'(sz);
      tick();
   endtask

   task automatic chk(input int r, input bit clear, input bit exp, input string req);
      chk_valid_i = 1'b1;
      chk_reg_i   = REG_W'(r);
      chk_clear_i = clear;
      #2;
      checks++;
      if (chk_pass_o !== exp || chk_fail_o !== !exp) begin
         errors++;
         $display("FAIL %s reg=%0d pass=%b fail=%b expected pass=%b", req, r,
                  chk_pass_o, chk_fail_o, exp);
      end
      tick();
   endtask

   task automatic t_reset();
      chk(5, 0, 0, "R2");
      chk(0, 0, 0, "R2");
   endtask

   task automatic t_insert_overlap();
      ins(5, 'h100, 2);
      chk(5, 0, 1, "R1");
      st('h104, 2);
      chk(5, 0, 1, "R4");
      st('h0FC, 2);
      chk(5, 0, 1, "R4");
      st('h103, 0);
      chk(5, 0, 0, "R3");
      ins(6, 'h200, 0);
      st('h1F8, 3);
      chk(6, 0, 1, "R4");
      st('h1FC, 3);
      chk(6, 0, 0, "R3");
   endtask

   task automatic t_overwrite();
      ins(7, 'h300, 2);
      ins(7, 'h400, 1);
      st('h300, 2);
      chk(7, 0, 1, "R5");
      st('h401, 0);
      chk(7, 0, 0, "R5");
   endtask

   task automatic t_same_cycle();
      ins_valid_i = 1'b1; ins_reg_i = 8; ins_addr_i = 'h500; ins_size_i = 2;
      st_valid_i  = 1'b1; st_addr_i = 'h500; st_size_i = 2;
      tick();
      chk(8, 0, 1, "R6");
   endtask

   task automatic t_clear();
      ins(9, 'h600, 3);
      chk(9, 0, 1, "R8");
      chk(9, 0, 1, "R8");
      chk(9, 1, 1, "R8");
      chk(9, 0, 0, "R8");
   endtask

   task automatic t_flush();
      ins(10, 'h700, 2);
      flush_i = 1'b1;
      tick();
      chk(10, 0, 0, "R9");
      chk(8, 0, 0, "R9");
      flush_i = 1'b1;
      ins_valid_i = 1'b1; ins_reg_i = 11; ins_addr_i = 'h800; ins_size_i = 0;
      tick();
      chk(11, 0, 0, "R9");
   endtask

   task automatic t_evict();
      flush_i = 1'b1;
      tick();
      for (int i = 0; i < 16; i++) ins(i, 'h1000 + 16 * i, 2);
      chk(15, 0, 1, "R7");
      ins(20, 'h2000, 2);
      chk(0, 0, 0, "R7");
      chk(20, 0, 1, "R7");
      chk(1, 0, 1, "R7");
      ins(21, 'h2010, 2);
      chk(1, 0, 0, "R7");
      chk(2, 0, 1, "R7");
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_insert_overlap();
      t_overwrite();
      t_same_cycle();
      t_clear();
      t_flush();
      t_evict();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule